// File: doc/BRIEF.md
# Dual-Input Up/Down Counter

This block is a small binary counter with two count inputs instead of one clock and a direction pin. One input moves the value up and the other moves it down. A step is taken only on a rising edge of one count input while the other input rests high. Both count inputs are asynchronous to the chip. They pass through a synchronizer on the system clock and are then edge-detected, so a qualifying edge changes the count a fixed number of system-clock cycles later.

Two controls act at once, without waiting for a count edge. A master clear forces the value to zero. A parallel load forces the value to a data word. Clear wins over load, and both block counting. Two active-low terminal outputs let stages be chained with no glue logic. Each one feeds the matching count input of the next stage.

The count, clear, load and data pins are plain control and status wires. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `udc_dual_counter`

## Requirements
- R1: While `rst_n` is low the count is 0. After reset, with both count inputs high, `carry_n` and `borrow_n` read 1.
- R2: A rising edge on `up_in` while `dn_in` is high adds one to `count`. If the edge is launched between system-clock edges, the new value appears after the third following rising clock edge, not earlier.
- R3: A rising edge on `dn_in` while `up_in` is high subtracts one from `count`, with the same latency as R2.
- R4: Counting wraps. Counting up from the all-ones value gives 0, and counting down from 0 gives the all-ones value (15 at the default width of 4).
- R5: While `clear` is high, `count` reads 0 at once, with no clock edge needed. The value stays 0 after `clear` is released.
- R6: While `load` is high and `clear` is low, `count` equals `din` at once. If `load` spans at least one system-clock edge, that value is kept after release.
- R7: When `clear` and `load` are both high, `count` reads 0.
- R8: Count edges that arrive while `clear` or `load` is high are discarded and leave no step behind.
- R9: The count does not change in two cases: when rising edges reach both count inputs in the same synchronized cycle, or when an edge arrives while the other count input is low.
- R10: `carry_n` is 0 exactly while the synchronized `up_in` is low and the count is all ones. `borrow_n` is 0 exactly while the synchronized `dn_in` is low and the count is 0.
- R11: Falling edges on either count input never change the count.
- R12: Feeding `carry_n` to the next stage's `up_in` and `borrow_n` to its `dn_in` makes the two stages behave as one wider counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the count inputs |
| rst_n | input | 1 | Active-low system reset |
| up_in | input | 1 | Asynchronous up-count input, idles high |
| dn_in | input | 1 | Asynchronous down-count input, idles high |
| clear | input | 1 | Asynchronous master clear, active high |
| load | input | 1 | Asynchronous parallel load, active high |
| din | input | WIDTH | Word copied in by `load` |
| count | output | WIDTH | Current count value |
| carry_n | output | 1 | Active-low terminal count for counting up |
| borrow_n | output | 1 | Active-low terminal count for counting down |

## Verification
On every clock, the assertions check the following:
- a granted step moves the stored value by exactly one, with wrap at the ends;
- without a step the value holds;
- a clear or a load leaves the stored value it promises;
- each detected edge is a single-cycle pulse.

Some behaviour only the bench's scenarios can show. These are the three-edge latency, the output reacting to clear or load in the middle of a cycle, and edges being lost rather than delayed while clear or load is held. The same applies to the rejection of simultaneous or badly gated edges, and to carries rippling into a second chained stage.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DN   = 2'b10
  } step_e;
endpackage

// File: rtl/udc_edge_sync.sv
module udc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  // Idle level is high, so reset to 1 to avoid a false edge after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last;

  assert_rise_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/udc_step_arbiter.sv
module udc_step_arbiter
  import udc_pkg::*;
(
  input  logic  rise_up,
  input  logic  rise_dn,
  input  logic  lvl_up,
  input  logic  lvl_dn,
  input  logic  hold,
  output step_e step
);
  always_comb begin
    step = STEP_NONE;
    if (!hold) begin
      if (rise_up && !rise_dn && lvl_dn)      step = STEP_UP;
      else if (rise_dn && !rise_up && lvl_up) step = STEP_DN;
    end
  end
endmodule

// File: rtl/udc_count_core.sv
module udc_count_core
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  step_e            step,
  output logic [WIDTH-1:0] count_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n or posedge clear) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (load)   cnt_q <= din;
    else begin
      unique case (step)
        STEP_UP: cnt_q <= cnt_q + ONE;
        STEP_DN: cnt_q <= cnt_q - ONE;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // Clear and load reach the output without waiting for a clock edge.
  always_comb begin
    if (clear)     count_o = '0;
    else if (load) count_o = din;
    else           count_o = cnt_q;
  end

  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (step == STEP_UP && !load) |=> cnt_q == $past(cnt_q) + ONE);
  assert_step_dn_R3: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (step == STEP_DN && !load) |=> cnt_q == $past(cnt_q) - ONE);
  assert_wrap_up_R4: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (step == STEP_UP && !load && cnt_q == TOP) |=> cnt_q == '0);
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt_q == '0);
  assert_load_keep_R6: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (load && !clear) |=> cnt_q == $past(din));
  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && load) |=> cnt_q == '0);
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (step == STEP_NONE && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/udc_dual_counter.sv
module udc_dual_counter
  import udc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_in,
  input  logic             dn_in,
  input  logic             clear,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic  lvl_up, lvl_dn, rise_up, rise_dn;
  step_e step;

  udc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_up (
    .clk(clk), .rst_n(rst_n), .async_in(up_in), .level(lvl_up), .rise(rise_up));
  udc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_dn (
    .clk(clk), .rst_n(rst_n), .async_in(dn_in), .level(lvl_dn), .rise(rise_dn));

  udc_step_arbiter u_arb (
    .rise_up(rise_up), .rise_dn(rise_dn), .lvl_up(lvl_up), .lvl_dn(lvl_dn),
    .hold(clear | load), .step(step));

  udc_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load(load), .din(din),
    .step(step), .count_o(count));

  assign carry_n  = ~(~lvl_up & (count == TOP));
  assign borrow_n = ~(~lvl_dn & (count == '0));

  assert_step_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_up && rise_dn) |-> step == STEP_NONE);
  assert_no_step_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear || load) |-> step == STEP_NONE);
endmodule

// File: tb/udc_dual_counter_test.sv
module udc_dual_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_in = 1'b1, dn_in = 1'b1, clear = 1'b0, load = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] count, count_hi, din_hi;
  logic carry_n, borrow_n, carry_hi, borrow_hi;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  udc_dual_counter #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .up_in(up_in), .dn_in(dn_in), .clear(clear),
    .load(load), .din(din), .count(count), .carry_n(carry_n), .borrow_n(borrow_n));

  assign din_hi = '0;
  udc_dual_counter #(.WIDTH(W)) uut_next (
    .clk(clk), .rst_n(rst_n), .up_in(carry_n), .dn_in(borrow_n), .clear(clear),
    .load(1'b0), .din(din_hi), .count(count_hi), .carry_n(carry_hi), .borrow_n(borrow_hi));

  // op 0: up pulse, 1: down pulse, 2: load; fields {op, din, expected count}
  localparam logic [9:0] VEC [12] = '{
    {2'd2, 4'd13, 4'd13}, {2'd0, 4'd0, 4'd14}, {2'd0, 4'd0, 4'd15},
    {2'd0, 4'd0, 4'd0},   {2'd1, 4'd0, 4'd15}, {2'd1, 4'd0, 4'd14},
    {2'd2, 4'd0, 4'd0},   {2'd1, 4'd0, 4'd15}, {2'd0, 4'd0, 4'd0},
    {2'd2, 4'd5, 4'd5},   {2'd1, 4'd0, 4'd4},  {2'd0, 4'd0, 4'd5}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up();
    @(negedge clk); up_in = 1'b0; waitn(4); up_in = 1'b1; waitn(4);
  endtask

  task automatic pulse_dn();
    @(negedge clk); dn_in = 1'b0; waitn(4); dn_in = 1'b1; waitn(4);
  endtask

  task automatic do_load(input logic [W-1:0] v);
    @(negedge clk); din = v; load = 1'b1; waitn(2); load = 1'b0; waitn(1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    waitn(3);
    check("R1 count", int'(count), 0);
    rst_n = 1'b1;
    waitn(2);
    check("R1 count", int'(count), 0);
    check("R1 carry_n", int'(carry_n), 1);
    check("R1 borrow_n", int'(borrow_n), 1);

    for (int i = 0; i < 12; i++) begin
      logic [1:0] op;
      op = VEC[i][9:8];
      if (op == 2'd0) pulse_up();
      else if (op == 2'd1) pulse_dn();
      else do_load(VEC[i][7:4]);
      check("R2/R3/R4/R6 table", int'(count), int'(VEC[i][3:0]));
    end

    // R2 latency: unchanged after two clock edges, updated after the third
    @(negedge clk); up_in = 1'b0; waitn(4);
    up_in = 1'b1; waitn(2);
    check("R2 early", int'(count), 5);
    waitn(1);
    check("R2 latency", int'(count), 6);
    waitn(2);

    // R11 falling edge does nothing
    up_in = 1'b0; waitn(5);
    check("R11 falling", int'(count), 6);
    up_in = 1'b1; waitn(4);
    check("R2 rise", int'(count), 7);

    // R9 simultaneous edges
    up_in = 1'b0; dn_in = 1'b0; waitn(4);
    up_in = 1'b1; dn_in = 1'b1; waitn(5);
    check("R9 simultaneous", int'(count), 7);

    // R9 up edge while dn low
    dn_in = 1'b0; waitn(4);
    up_in = 1'b0; waitn(4); up_in = 1'b1; waitn(4);
    check("R9 gated", int'(count), 7);
    dn_in = 1'b1; waitn(4);
    check("R3 dn edge", int'(count), 6);

    // R5 asynchronous clear
    @(negedge clk); #2 clear = 1'b1; #1;
    check("R5 immediate", int'(count), 0);
    waitn(2); clear = 1'b0; waitn(2);
    check("R5 held", int'(count), 0);

    // R7 clear over load
    din = 4'd9; load = 1'b1; clear = 1'b1; #1;
    check("R7 priority", int'(count), 0);
    waitn(2); load = 1'b0; clear = 1'b0; waitn(2);
    check("R7 after", int'(count), 0);

    // R6 load
    @(negedge clk); #2 din = 4'd10; load = 1'b1; #1;
    check("R6 immediate", int'(count), 10);
    waitn(2); load = 1'b0; waitn(2);
    check("R6 kept", int'(count), 10);

    // R8 edges during load discarded
    @(negedge clk); din = 4'd6; load = 1'b1;
    pulse_up(); pulse_up(); pulse_dn();
    check("R8 during", int'(count), 6);
    load = 1'b0; waitn(5);
    check("R8 after", int'(count), 6);

    // R10 carry and borrow
    do_load(4'd15);
    check("R10 carry idle", int'(carry_n), 1);
    up_in = 1'b0; waitn(4);
    check("R10 carry low", int'(carry_n), 0);
    check("R10 borrow", int'(borrow_n), 1);
    up_in = 1'b1; waitn(4);
    check("R4 wrap up", int'(count), 0);
    check("R10 carry high", int'(carry_n), 1);
    dn_in = 1'b0; waitn(4);
    check("R10 borrow low", int'(borrow_n), 0);
    dn_in = 1'b1; waitn(4);
    check("R4 wrap dn", int'(count), 15);
    check("R10 borrow high", int'(borrow_n), 1);

    // R12 cascade
    clear = 1'b1; waitn(2); clear = 1'b0; waitn(2);
    check("R12 cleared", int'(count_hi), 0);
    do_load(4'd15);
    pulse_up(); waitn(4);
    check("R12 low stage", int'(count), 0);
    check("R12 high stage up", int'(count_hi), 1);
    pulse_dn(); waitn(4);
    check("R12 low stage", int'(count), 15);
    check("R12 high stage dn", int'(count_hi), 0);

    done = 1'b1;
    finish_run();
  end
endmodule